// File: doc/BRIEF.md
# Snooping Cache Bus-Side Responder

This block is the bus-facing half of a write-back board-level cache that sits on a shared snooping system bus. Every transaction that another commander starts on the bus is seen by this block. For each one, the block looks up the line in its tag and control store. On a write hit it either drops the line or refreshes it with the bus data. On a read-type hit it reports that it holds a copy. When its copy is dirty, it supplies the block itself, so that memory does not answer with stale data.

Each transaction runs a fixed number of bus cycles. Cycle 0 is the cycle in which the command strobe is seen. The tag probe happens in cycle 1, and the snoop responses are driven from cycle 2 onward. A write that updates the local copy stretches the transaction from six to nine cycles, and the block signals this with a hold output. A local fill port and a lookup port stand in for the processor side of the arrays. They let the lines be preloaded and inspected.

Top module: `snoop_responder`

## Requirements
- R1: Commands are encoded on `bus_cmd` as 00 no-op, 01 write, 10 read and 11 exchange. A strobe on `bus_cmd_valid` starts a transaction only while `snp_busy` is low. `snp_busy` is high from cycle 1 to the last cycle of the transaction. Strobes while busy are ignored.
- R2: A write lasts 6 cycles, or 9 cycles when it updates a hit line. Read, exchange and no-op last 7 cycles. `snp_busy` is low in the cycle after the last one.
- R3: A probe hits when the indexed line (address bits [2:0]) is valid and its stored tag equals address bits [9:3]. A miss drives no snoop response and changes no line.
- R4: A write hit with `cfg_update` low clears the line's valid and dirty bits at the end of the transaction. The shared bit and data are kept, and no snoop response is driven.
- R5: A write hit with `cfg_update` high (sampled in cycle 1) stores bus data beats from cycles 2 and 3 (beat 0 in the low half). It clears dirty and keeps valid and the previous shared bit. It drives `bus_shared` in cycles 2 to 8 and `bus_hold` in cycles 6 to 8.
- R6: A read hit on a dirty line drives `bus_shared` and `bus_dirty` in cycles 2 to 6. It drives the line on `bus_rdata` with `bus_rdata_valid` in cycles 5 (low beat) and 6 (high beat). The line stays dirty afterwards.
- R7: An exchange is probed exactly like a read, including dirty-hit data supply.
- R8: A read hit on a clean line drives only `bus_shared` in cycles 2 to 6 and leaves the line unchanged.
- R9: A no-op transaction drives no snoop response and changes no line, whatever the address.
- R10: After reset every line is invalid, and all bus outputs and `snp_busy` are low.
- R11: While the block is idle, `fill_en` writes the tag, valid, dirty, shared and data of the line addressed by `fill_addr`. The lookup outputs show the stored bits and data of the line indexed by `lk_addr`, with `lk_tag_eq` high when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_update | input | 1 | Write-hit policy: 1 update, 0 invalidate |
| bus_cmd_valid | input | 1 | Command strobe (cycle 0) |
| bus_cmd | input | 2 | Command code |
| bus_addr | input | 10 | Line address |
| bus_wdata | input | 16 | Write data beat |
| bus_shared | output | 1 | Shared snoop response |
| bus_dirty | output | 1 | Dirty intervention, memory must not answer |
| bus_rdata_valid | output | 1 | Read data beat valid |
| bus_rdata | output | 16 | Read data beat |
| bus_hold | output | 1 | Write stretched for update |
| snp_busy | output | 1 | Transaction in progress |
| fill_en | input | 1 | Local line write |
| fill_addr | input | 10 | Local line address |
| fill_valid | input | 1 | Valid bit to store |
| fill_dirty | input | 1 | Dirty bit to store |
| fill_shared | input | 1 | Shared bit to store |
| fill_data | input | 32 | Line data to store |
| lk_addr | input | 10 | Lookup address |
| lk_tag_eq | output | 1 | Stored tag matches |
| lk_valid | output | 1 | Stored valid bit |
| lk_dirty | output | 1 | Stored dirty bit |
| lk_shared | output | 1 | Stored shared bit |
| lk_data | output | 32 | Stored line data |

## Verification
The assertions check properties that hold on every cycle:
- intervention appears only on read or exchange;
- read data appears only under intervention;
- the hold appears only on an updating write that also asserts shared;
- no-op transactions stay silent;
- responses stay stable once driven;
- strobes during a transaction do not disturb the latched address;
- the cycle counter stays in bounds;
- lines come out of reset invalid.

Only the directed scenarios can show the exact cycle windows of each response, the returned beat order, the transaction lengths and the line state that each command leaves behind.

// File: rtl/snp_pkg.sv
package snp_pkg;

    localparam int CYC_W = 4;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_WR   = 2'b01,
        CMD_RD   = 2'b10,
        CMD_XCHG = 2'b11
    } snp_cmd_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic shared;
    } line_ctrl_t;

    localparam logic [CYC_W-1:0] LEN_WR_PLAIN = 4'd6;
    localparam logic [CYC_W-1:0] LEN_WR_UPD   = 4'd9;
    localparam logic [CYC_W-1:0] LEN_READLIKE = 4'd7;
    localparam logic [CYC_W-1:0] CYC_PROBE    = 4'd1;
    localparam logic [CYC_W-1:0] CYC_RESP     = 4'd2;
    localparam logic [CYC_W-1:0] CYC_HOLD     = 4'd6;

    function automatic logic [CYC_W-1:0] txn_len(snp_cmd_e c, logic upd);
        if (c == CMD_WR) return upd ? LEN_WR_UPD : LEN_WR_PLAIN;
        return LEN_READLIKE;
    endfunction

    function automatic logic is_readlike(snp_cmd_e c);
        return (c == CMD_RD) || (c == CMD_XCHG);
    endfunction

endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
    import snp_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 7,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  pr_idx,
    input  logic [TAG_W-1:0]  pr_tag,
    output logic              pr_tag_eq,
    output line_ctrl_t        pr_ctrl,
    output logic [LINE_W-1:0] pr_data,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_tag_eq,
    output line_ctrl_t        lk_ctrl,
    output logic [LINE_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  line_ctrl_t        wr_ctrl,
    input  logic [LINE_W-1:0] wr_data
);
    localparam int NLINE = 1 << IDX_W;

    logic [NLINE-1:0][TAG_W-1:0]  tag_all;
    line_ctrl_t [NLINE-1:0]       ctrl_all;
    logic [NLINE-1:0][LINE_W-1:0] data_all;

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        logic [TAG_W-1:0]  tag_r;
        line_ctrl_t        ctrl_r;
        logic [LINE_W-1:0] data_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_r  <= '0;
                ctrl_r <= '0;
                data_r <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                tag_r  <= wr_tag;
                ctrl_r <= wr_ctrl;
                data_r <= wr_data;
            end
        end
        assign tag_all[g]  = tag_r;
        assign ctrl_all[g] = ctrl_r;
        assign data_all[g] = data_r;
    end

    assign pr_tag_eq = (tag_all[pr_idx] == pr_tag);
    assign pr_ctrl   = ctrl_all[pr_idx];
    assign pr_data   = data_all[pr_idx];
    assign lk_tag_eq = (tag_all[lk_idx] == lk_tag);
    assign lk_ctrl   = ctrl_all[lk_idx];
    assign lk_data   = data_all[lk_idx];

    // R10: the cycle after reset, no line reads as valid
    a_r10_lines_invalid_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !lk_ctrl.valid && !pr_ctrl.valid);

endmodule

// File: rtl/snp_sequencer.sv
module snp_sequencer
    import snp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 3,
    parameter int BEAT_W = 16,
    parameter int NBEAT  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_update,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_in,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic [BEAT_W-1:0]       wdata_in,
    output logic [IDX_W-1:0]        pr_idx,
    output logic [ADDR_W-IDX_W-1:0] pr_tag,
    input  logic                    pr_tag_eq,
    input  line_ctrl_t              pr_ctrl,
    input  logic [BEAT_W*NBEAT-1:0] pr_data,
    output logic                    cm_en,
    output line_ctrl_t              cm_ctrl,
    output logic [BEAT_W*NBEAT-1:0] cm_data,
    output logic                    busy,
    output logic                    shared_o,
    output logic                    dirty_o,
    output logic                    rvalid_o,
    output logic [BEAT_W-1:0]       rdata_o,
    output logic                    hold_o
);
    localparam int LINE_W = BEAT_W * NBEAT;

    logic              active;
    logic [CYC_W-1:0]  cyc;
    snp_cmd_e          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              hit_q, upd_q, shr_q, itv_q;
    line_ctrl_t        ctrl_q;
    logic [LINE_W-1:0] data_q, wbuf;
    logic [CYC_W-1:0]  len_cur;
    logic              last_cyc, hit_now;

    assign pr_idx   = addr_q[IDX_W-1:0];
    assign pr_tag   = addr_q[ADDR_W-1:IDX_W];
    assign hit_now  = pr_ctrl.valid && pr_tag_eq;
    assign len_cur  = txn_len(cmd_q, upd_q);
    assign last_cyc = active && (cyc == len_cur - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cyc    <= '0;
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            hit_q  <= 1'b0;
            upd_q  <= 1'b0;
            shr_q  <= 1'b0;
            itv_q  <= 1'b0;
            ctrl_q <= '0;
            data_q <= '0;
            wbuf   <= '0;
        end else if (!active) begin
            if (cmd_valid) begin
                active <= 1'b1;
                cyc    <= 4'd1;
                cmd_q  <= snp_cmd_e'(cmd_in);
                addr_q <= addr_in;
                hit_q  <= 1'b0;
                upd_q  <= 1'b0;
                shr_q  <= 1'b0;
                itv_q  <= 1'b0;
            end
        end else begin
            cyc <= cyc + 4'd1;
            if (last_cyc) active <= 1'b0;
            if (cyc == CYC_PROBE) begin
                hit_q  <= hit_now;
                ctrl_q <= pr_ctrl;
                data_q <= pr_data;
                upd_q  <= (cmd_q == CMD_WR) && hit_now && cfg_update;
                shr_q  <= (is_readlike(cmd_q) && hit_now) ||
                          ((cmd_q == CMD_WR) && hit_now && cfg_update);
                itv_q  <= is_readlike(cmd_q) && hit_now && pr_ctrl.dirty;
            end
            if (cmd_q == CMD_WR) begin
                for (int b = 0; b < NBEAT; b++) begin
                    if (cyc == CYC_RESP + CYC_W'(b)) wbuf[b*BEAT_W +: BEAT_W] <= wdata_in;
                end
            end
        end
    end

    // line write-back at the final cycle of a write hit
    always_comb begin
        cm_en   = last_cyc && (cmd_q == CMD_WR) && hit_q;
        cm_ctrl = ctrl_q;
        cm_data = data_q;
        if (upd_q) begin
            cm_ctrl.dirty = 1'b0;
            cm_data       = wbuf;
        end else begin
            cm_ctrl.valid = 1'b0;
            cm_ctrl.dirty = 1'b0;
        end
    end

    logic in_resp;
    assign in_resp  = active && (cyc >= CYC_RESP);
    assign busy     = active;
    assign shared_o = in_resp && shr_q;
    assign dirty_o  = in_resp && itv_q;
    assign hold_o   = in_resp && upd_q && (cyc >= CYC_HOLD);

    always_comb begin
        rvalid_o = 1'b0;
        rdata_o  = '0;
        for (int b = 0; b < NBEAT; b++) begin
            if (in_resp && itv_q && (cyc == len_cur - CYC_W'(NBEAT) + CYC_W'(b))) begin
                rvalid_o = 1'b1;
                rdata_o  = data_q[b*BEAT_W +: BEAT_W];
            end
        end
    end

    a_r6_intervene_only_readlike: assert property (@(posedge clk) disable iff (rst)
        dirty_o |-> (cmd_q == CMD_RD) || (cmd_q == CMD_XCHG));
    a_r6_data_under_intervention: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |-> dirty_o && shared_o);
    a_r5_hold_only_updating_write: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> shared_o && (cmd_q == CMD_WR));
    a_r9_nop_silent: assert property (@(posedge clk) disable iff (rst)
        (active && cmd_q == CMD_NOP) |-> !shared_o && !dirty_o && !rvalid_o && !cm_en);
    a_r2_cycle_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (cyc >= 4'd1) && (cyc <= 4'd8));
    a_r8_shared_steady: assert property (@(posedge clk) disable iff (rst)
        (active && cyc > CYC_RESP) |-> $stable(shared_o) && $stable(dirty_o));
    a_r1_strobe_ignored_when_busy: assert property (@(posedge clk) disable iff (rst)
        (active && !last_cyc) |=> $stable(addr_q) && $stable(cmd_q));

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
    import snp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 3,
    parameter int BEAT_W = 16,
    parameter int NBEAT  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_update,
    input  logic                    bus_cmd_valid,
    input  logic [1:0]              bus_cmd,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BEAT_W-1:0]       bus_wdata,
    output logic                    bus_shared,
    output logic                    bus_dirty,
    output logic                    bus_rdata_valid,
    output logic [BEAT_W-1:0]       bus_rdata,
    output logic                    bus_hold,
    output logic                    snp_busy,
    input  logic                    fill_en,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic                    fill_valid,
    input  logic                    fill_dirty,
    input  logic                    fill_shared,
    input  logic [BEAT_W*NBEAT-1:0] fill_data,
    input  logic [ADDR_W-1:0]       lk_addr,
    output logic                    lk_tag_eq,
    output logic                    lk_valid,
    output logic                    lk_dirty,
    output logic                    lk_shared,
    output logic [BEAT_W*NBEAT-1:0] lk_data
);
    localparam int LINE_W = BEAT_W * NBEAT;
    localparam int TAG_W  = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  pr_idx, wr_idx;
    logic [TAG_W-1:0]  pr_tag, wr_tag;
    logic              pr_tag_eq, cm_en, wr_en;
    line_ctrl_t        pr_ctrl, cm_ctrl, wr_ctrl, lk_ctrl;
    logic [LINE_W-1:0] pr_data, cm_data, wr_data;

    snp_sequencer #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_W(BEAT_W), .NBEAT(NBEAT)
    ) seq_i (
        .clk(clk), .rst(rst), .cfg_update(cfg_update),
        .cmd_valid(bus_cmd_valid), .cmd_in(bus_cmd), .addr_in(bus_addr),
        .wdata_in(bus_wdata),
        .pr_idx(pr_idx), .pr_tag(pr_tag), .pr_tag_eq(pr_tag_eq),
        .pr_ctrl(pr_ctrl), .pr_data(pr_data),
        .cm_en(cm_en), .cm_ctrl(cm_ctrl), .cm_data(cm_data),
        .busy(snp_busy), .shared_o(bus_shared), .dirty_o(bus_dirty),
        .rvalid_o(bus_rdata_valid), .rdata_o(bus_rdata), .hold_o(bus_hold)
    );

    // snoop write-back takes priority over a local fill
    always_comb begin
        if (cm_en) begin
            wr_en   = 1'b1;
            wr_idx  = pr_idx;
            wr_tag  = pr_tag;
            wr_ctrl = cm_ctrl;
            wr_data = cm_data;
        end else begin
            wr_en   = fill_en;
            wr_idx  = fill_addr[IDX_W-1:0];
            wr_tag  = fill_addr[ADDR_W-1:IDX_W];
            wr_ctrl = '{valid: fill_valid, dirty: fill_dirty, shared: fill_shared};
            wr_data = fill_data;
        end
    end

    snp_line_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) store_i (
        .clk(clk), .rst(rst),
        .pr_idx(pr_idx), .pr_tag(pr_tag), .pr_tag_eq(pr_tag_eq),
        .pr_ctrl(pr_ctrl), .pr_data(pr_data),
        .lk_idx(lk_addr[IDX_W-1:0]), .lk_tag(lk_addr[ADDR_W-1:IDX_W]),
        .lk_tag_eq(lk_tag_eq), .lk_ctrl(lk_ctrl), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data)
    );

    assign lk_valid  = lk_ctrl.valid;
    assign lk_dirty  = lk_ctrl.dirty;
    assign lk_shared = lk_ctrl.shared;

    // R10: outputs idle while in reset's aftermath
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !snp_busy && !bus_shared && !bus_dirty && !bus_hold && !bus_rdata_valid);

endmodule

// File: tb/snoop_responder_tb_top.sv
module snoop_responder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_update = 1'b0;
    logic        bus_cmd_valid = 1'b0;
    logic [1:0]  bus_cmd = 2'b00;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_shared, bus_dirty, bus_rdata_valid, bus_hold, snp_busy;
    logic [15:0] bus_rdata;
    logic        fill_en = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0, fill_shared = 1'b0;
    logic [9:0]  fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic [9:0]  lk_addr = '0;
    logic        lk_tag_eq, lk_valid, lk_dirty, lk_shared;
    logic [31:0] lk_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_count = 0;

    always #5 clk = ~clk;

    snoop_responder dut_i (
        .clk(clk), .rst(rst), .cfg_update(cfg_update),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata),
        .bus_shared(bus_shared), .bus_dirty(bus_dirty),
        .bus_rdata_valid(bus_rdata_valid), .bus_rdata(bus_rdata),
        .bus_hold(bus_hold), .snp_busy(snp_busy),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_valid(fill_valid),
        .fill_dirty(fill_dirty), .fill_shared(fill_shared), .fill_data(fill_data),
        .lk_addr(lk_addr), .lk_tag_eq(lk_tag_eq), .lk_valid(lk_valid),
        .lk_dirty(lk_dirty), .lk_shared(lk_shared), .lk_data(lk_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [9:0] a, input bit v, input bit d, input bit s,
                        input logic [31:0] data);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = a; fill_valid = v; fill_dirty = d;
        fill_shared = s; fill_data = data;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic expect_line(input string req, input logic [9:0] a, input bit v,
                               input bit d, input bit s, input logic [31:0] data);
        lk_addr = a;
        #1;
        check(req, "lookup tag_eq", 32'(lk_tag_eq), 32'(1));
        check(req, "lookup valid",  32'(lk_valid),  32'(v));
        check(req, "lookup dirty",  32'(lk_dirty),  32'(d));
        check(req, "lookup shared", 32'(lk_shared), 32'(s));
        check(req, "lookup data",   lk_data, data);
    endtask

    // Drive one bus transaction and check every cycle against expectations.
    task automatic run_txn(input string req, input logic [1:0] cmd, input logic [9:0] a,
                           input logic [31:0] wline, input int len, input bit sh,
                           input bit itv, input bit hold, input logic [31:0] rline,
                           input int inject_at);
        @(negedge clk);
        bus_cmd_valid = 1'b1; bus_cmd = cmd; bus_addr = a;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            bus_cmd_valid = (k == inject_at);
            bus_cmd       = (k == inject_at) ? 2'b10 : cmd;
            bus_addr      = (k == inject_at) ? ~a : a;
            bus_wdata     = (k == 2) ? wline[15:0] : ((k == 3) ? wline[31:16] : 16'h0);
            if (k < len) begin
                bit rv;
                rv = itv && (k >= len - 2);
                check(req, $sformatf("busy c%0d", k), 32'(snp_busy), 32'(1));
                check(req, $sformatf("shared c%0d", k), 32'(bus_shared), 32'(sh && k >= 2));
                check(req, $sformatf("dirty c%0d", k), 32'(bus_dirty), 32'(itv && k >= 2));
                check(req, $sformatf("rvalid c%0d", k), 32'(bus_rdata_valid), 32'(rv));
                check(req, $sformatf("hold c%0d", k), 32'(bus_hold), 32'(hold && k >= 6));
                if (rv)
                    check(req, $sformatf("rdata c%0d", k), 32'(bus_rdata),
                          (k == len - 2) ? 32'(rline[15:0]) : 32'(rline[31:16]));
            end else begin
                check(req, "busy after end", 32'(snp_busy), 32'(0));
                check(req, "shared after end", 32'(bus_shared), 32'(0));
                check(req, "dirty after end", 32'(bus_dirty), 32'(0));
            end
        end
        bus_cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R10", "busy", 32'(snp_busy), 32'(0));
        check("R10", "shared", 32'(bus_shared), 32'(0));
        check("R10", "dirty", 32'(bus_dirty), 32'(0));
        check("R10", "hold", 32'(bus_hold), 32'(0));
        for (int i = 0; i < 8; i++) begin
            lk_addr = 10'(i); #1;
            check("R10", $sformatf("line %0d valid", i), 32'(lk_valid), 32'(0));
        end
    endtask

    task automatic t_fill_lookup();
        fill(10'h0A1, 1, 0, 0, 32'h1357_9BDF);
        expect_line("R11", 10'h0A1, 1, 0, 0, 32'h1357_9BDF);
    endtask

    task automatic t_clean_read();
        run_txn("R8", 2'b10, 10'h0A1, 0, 7, 1, 0, 0, 0, 0);
        expect_line("R8", 10'h0A1, 1, 0, 0, 32'h1357_9BDF);
    endtask

    task automatic t_miss();
        run_txn("R3", 2'b10, 10'h0B1, 0, 7, 0, 0, 0, 0, 0);
        expect_line("R3", 10'h0A1, 1, 0, 0, 32'h1357_9BDF);
    endtask

    task automatic t_dirty_read();
        fill(10'h0C2, 1, 1, 1, 32'hBEEF_1234);
        run_txn("R6", 2'b10, 10'h0C2, 0, 7, 1, 1, 0, 32'hBEEF_1234, 0);
        expect_line("R6", 10'h0C2, 1, 1, 1, 32'hBEEF_1234);
    endtask

    task automatic t_exchange();
        run_txn("R7", 2'b11, 10'h0C2, 0, 7, 1, 1, 0, 32'hBEEF_1234, 0);
        expect_line("R7", 10'h0C2, 1, 1, 1, 32'hBEEF_1234);
    endtask

    task automatic t_nop();
        run_txn("R9", 2'b00, 10'h0C2, 0, 7, 0, 0, 0, 0, 0);
        expect_line("R9", 10'h0C2, 1, 1, 1, 32'hBEEF_1234);
    endtask

    task automatic t_write_inval();
        cfg_update = 1'b0;
        run_txn("R4", 2'b01, 10'h0C2, 32'h7777_8888, 6, 0, 0, 0, 0, 0);
        expect_line("R4", 10'h0C2, 0, 0, 1, 32'hBEEF_1234);
        run_txn("R3", 2'b10, 10'h0C2, 0, 7, 0, 0, 0, 0, 0);
    endtask

    task automatic t_write_update();
        cfg_update = 1'b1;
        fill(10'h0F3, 1, 0, 0, 32'h1111_2222);
        run_txn("R5", 2'b01, 10'h0F3, 32'h5555_AAAA, 9, 1, 0, 1, 0, 0);
        expect_line("R5", 10'h0F3, 1, 0, 0, 32'h5555_AAAA);
        fill(10'h1A4, 1, 1, 1, 32'h0F0F_0F0F);
        run_txn("R5", 2'b01, 10'h1A4, 32'hC0DE_D00D, 9, 1, 0, 1, 0, 0);
        expect_line("R5", 10'h1A4, 1, 0, 1, 32'hC0DE_D00D);
    endtask

    task automatic t_write_miss();
        cfg_update = 1'b1;
        run_txn("R2", 2'b01, 10'h2F3, 32'hDEAD_BEEF, 6, 0, 0, 0, 0, 0);
        expect_line("R3", 10'h0F3, 1, 0, 0, 32'h5555_AAAA);
    endtask

    task automatic t_busy_ignore();
        run_txn("R1", 2'b10, 10'h0A1, 0, 7, 1, 0, 0, 0, 3);
        run_txn("R1", 2'b11, 10'h0F3, 0, 7, 1, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_count);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_lookup();
        t_clean_read();
        t_miss();
        t_dirty_read();
        t_exchange();
        t_nop();
        t_write_inval();
        t_write_update();
        t_write_miss();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule